// File: doc/BRIEF.md
# Adaptive DMA Request Reassertion Timer

This block decides when a bus-mastering device may drive its DMA request line again after the host DMA controller removes the acknowledge. It watches the request lines of all four DMA channels the device can use. When the acknowledge goes away, it checks whether any channel ranked below the device's own channel is waiting for service. If one is, the block holds the request off for the long interval. If none is, it uses the short interval and asks for the bus again as soon as that interval ends. A master on a high-priority channel therefore cannot keep a lower-priority master off the bus, and it loses no throughput when nobody else is waiting.

Both intervals are given in nanoseconds and converted to clock cycles from a clock-frequency parameter, rounding up so that neither interval is ever shorter than its nanosecond value. The other channels' request lines come from outside the clock domain, so a two-stage synchronizer samples them. A reset synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `dma_req_pacer`

## Requirements
- R1: While reset is active and after it is released, `drq_out` is low until a bus request is pending.
- R2: With `want_bus` high, `dack` low and no holdoff running, `drq_out` goes high one clock edge after `want_bus` rises. It goes low one edge after `want_bus` falls.
- R3: One clock edge after `dack` is sampled high, `drq_out` is low. It stays low for as long as `dack` stays high.
- R4: If no lower-priority request is pending, `drq_out` first rises exactly `SHORT_CYC` clock edges after the first edge that samples `dack` low. `SHORT_CYC` is ceil(`CLK_MHZ`·`SHORT_NS`/1000), which is 22 at 20 MHz and 1100 ns.
- R5: If a lower-priority request is seen, through its two-flop synchronizer, on the edge that samples `dack` low, `drq_out` first rises exactly `LONG_CYC` edges after that edge. `LONG_CYC` is ceil(`CLK_MHZ`·`LONG_NS`/1000), which is 52 at 20 MHz and 2600 ns.
- R6: `drq_in` bit k is the request line of priority rank k: bit 0 is the highest rank (channel 3), then bits 1, 2 and 3 (channels 5, 6 and 7). `chan_sel` gives the rank of the device's own channel. Only bits with an index greater than `chan_sel` count as lower priority. The device's own bit and higher-ranked bits never lengthen the holdoff.
- R7: If a lower-priority request appears while the short holdoff is still running, the holdoff is extended to `LONG_CYC` edges. A request that appears after `drq_out` has already risen does not drop `drq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 2 | Priority rank of the device's own channel (0 highest) |
| want_bus | input | 1 | Internal request for bus ownership |
| dack | input | 1 | DMA acknowledge from the host, active high |
| drq_in | input | 4 | Asynchronous request lines of all channels, indexed by rank |
| drq_out | output | 1 | Request drive for the device's own channel |

## Verification
A wrong holdoff count or a wrong short/long choice shows up only as the cycle on which `drq_out` first rises after a release. Each release is therefore measured to the exact edge against `SHORT_CYC` or `LONG_CYC`, for every channel rank combined with every pattern of the four request lines. A stale competition flag or a mis-ranked mask moves that edge by 30 cycles, so it is seen within one release. A late extension is also placed inside the short window, to show that the decision is re-evaluated on every cycle and not only when the acknowledge falls.

// File: rtl/dma_pacer_pkg.sv
package dma_pacer_pkg;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = $clog2(NUM_CH);

  // Converts a delay in ns to a clock-cycle count, rounding up.
  function automatic int ns_to_cycles(input int clk_mhz, input int ns);
    return (clk_mhz * ns + 999) / 1000;
  endfunction
endpackage

// File: rtl/drq_sync.sv
module drq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lower_prio_detect.sv
module lower_prio_detect
  import dma_pacer_pkg::*;
(
  input  logic [SEL_W-1:0]  own_rank,
  input  logic [NUM_CH-1:0] req,
  output logic              lower_hit
);
  logic [NUM_CH-1:0] below_mask;

  genvar k;
  generate
    for (k = 0; k < NUM_CH; k++) begin : g_mask
      assign below_mask[k] = (k > int'(own_rank));
    end
  endgenerate

  assign lower_hit = |(req & below_mask);
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int SHORT_CYC = 22,
  parameter int LONG_CYC  = 52,
  localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_bus,
  input  logic dack,
  input  logic lower_hit,
  output logic drq_out
);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

  logic             dack_q, dack_en;
  logic             hold_q, hold_n;
  logic             long_q, long_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             drq_q, drq_n;

  always_comb begin
    hold_n = hold_q;
    long_n = long_q;
    cnt_n  = cnt_q;
    if (dack) begin
      hold_n = 1'b0;
      long_n = 1'b0;
      cnt_n  = '0;
    end else if (dack_q) begin
      // acknowledge just released: start the holdoff window
      hold_n = 1'b1;
      long_n = lower_hit;
      cnt_n  = CNT_W'(1);
    end else if (hold_q) begin
      long_n = long_q | lower_hit;
      if (cnt_q >= (long_n ? LONG_LIM : SHORT_LIM)) hold_n = 1'b0;
      else cnt_n = cnt_q + CNT_W'(1);
    end
    drq_n   = want_bus & ~dack & ~hold_n;
    dack_en = (dack != dack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack_q <= 1'b0;
      hold_q <= 1'b0;
      long_q <= 1'b0;
      cnt_q  <= '0;
      drq_q  <= 1'b0;
    end else begin
      if (dack_en) dack_q <= dack;
      hold_q <= hold_n;
      long_q <= long_n;
      cnt_q  <= cnt_n;
      drq_q  <= drq_n;
    end
  end

  assign drq_out = drq_q;
endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer
  import dma_pacer_pkg::*;
#(
  parameter int CLK_MHZ  = 20,
  parameter int SHORT_NS = 1100,
  parameter int LONG_NS  = 2600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic              want_bus,
  input  logic              dack,
  input  logic [NUM_CH-1:0] drq_in,
  output logic              drq_out
);
  localparam int SHORT_CYC = ns_to_cycles(CLK_MHZ, SHORT_NS);
  localparam int LONG_CYC  = ns_to_cycles(CLK_MHZ, LONG_NS);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NUM_CH-1:0] drq_seen;
  logic              lower_hit;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  drq_sync #(.WIDTH(NUM_CH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(drq_in), .sync_out(drq_seen)
  );

  lower_prio_detect u_rank (
    .own_rank(chan_sel), .req(drq_seen), .lower_hit(lower_hit)
  );

  holdoff_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .want_bus(want_bus), .dack(dack),
    .lower_hit(lower_hit), .drq_out(drq_out)
  );
endmodule

// File: rtl/dma_req_pacer_chk.sv
module dma_req_pacer_chk
  import dma_pacer_pkg::*;
#(
  parameter int CLK_MHZ  = 20,
  parameter int SHORT_NS = 1100,
  parameter int LONG_NS  = 2600
) (
  input logic clk,
  input logic rst_n,
  input logic want_bus,
  input logic dack,
  input logic lower_hit,
  input logic drq_out
);
  localparam int SHORT_CYC = ns_to_cycles(CLK_MHZ, SHORT_NS);
  localparam int LONG_CYC  = ns_to_cycles(CLK_MHZ, LONG_NS);
  localparam int SW        = $clog2(LONG_CYC + 2);

  logic          prev_dack, armed, saw_low;
  logic [SW-1:0] since;

  // independent count of edges since the acknowledge was released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dack <= 1'b0;
      armed     <= 1'b0;
      saw_low   <= 1'b0;
      since     <= '0;
    end else begin
      prev_dack <= dack;
      if (dack) begin
        armed <= 1'b0;
        saw_low <= 1'b0;
      end else if (prev_dack) begin
        armed   <= 1'b1;
        saw_low <= lower_hit;
        since   <= '0;
      end else begin
        if (drq_out) armed <= 1'b0;
        if (int'(since) < SHORT_CYC) saw_low <= saw_low | lower_hit;
        if (int'(since) <= LONG_CYC) since <= since + SW'(1);
      end
    end
  end

  // R3
  dack_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !drq_out);

  // R2
  want_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !want_bus |=> !drq_out);

  // R4
  short_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_out && armed && !prev_dack && !dack) |-> (int'(since) >= SHORT_CYC));

  // R5
  long_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_out && armed && saw_low && !prev_dack && !dack) |-> (int'(since) >= LONG_CYC));
endmodule

bind dma_req_pacer dma_req_pacer_chk #(
  .CLK_MHZ(CLK_MHZ), .SHORT_NS(SHORT_NS), .LONG_NS(LONG_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .want_bus(want_bus), .dack(dack),
  .lower_hit(lower_hit), .drq_out(drq_out)
);

// File: tb/sim_dma_req_pacer.sv
module sim_dma_req_pacer;
  localparam int CLK_PERIOD = 50;
  localparam int MHZ   = 20;
  localparam int SHORT = (MHZ * 1100 + 999) / 1000;
  localparam int LONG  = (MHZ * 2600 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] chan_sel;
  logic       want_bus;
  logic       dack;
  logic [3:0] drq_in;
  logic       drq_out;

  int vectors = 0;
  int errs    = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_pacer #(.CLK_MHZ(MHZ), .SHORT_NS(1100), .LONG_NS(2600)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .want_bus(want_bus),
    .dack(dack), .drq_in(drq_in), .drq_out(drq_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Releases the acknowledge and returns the first j (negedge after edge E0+j) with drq high.
  // At j == ext_at the pattern ext_pat is applied (ext_at < 0 means never).
  task automatic release_and_time(input logic [1:0] sel, input logic [3:0] pat,
                                  input int ext_at, input logic [3:0] ext_pat,
                                  output int rise);
    @(negedge clk);
    chan_sel = sel; drq_in = pat; want_bus = 1'b1; dack = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", int'(drq_out), 0);
    dack = 1'b0;
    rise = -1;
    for (int j = 0; j <= LONG + 6; j++) begin
      @(negedge clk);
      if (drq_out && rise < 0) rise = j;
      if (rise >= 0 && !drq_out) chk("R7", int'(drq_out), 1);
      if (j == ext_at) drq_in = ext_pat;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; chan_sel = 2'd0; want_bus = 1'b0; dack = 1'b0; drq_in = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1", int'(drq_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", int'(drq_out), 0);
  endtask

  task automatic t_want;
    want_bus = 1'b1;
    @(negedge clk);
    chk("R2", int'(drq_out), 1);
    want_bus = 1'b0;
    @(negedge clk);
    chk("R2", int'(drq_out), 0);
    want_bus = 1'b1;
    @(negedge clk);
    chk("R2", int'(drq_out), 1);
  endtask

  task automatic t_dack;
    dack = 1'b1;
    @(negedge clk);
    chk("R3", int'(drq_out), 0);
    repeat (10) @(negedge clk);
    chk("R3", int'(drq_out), 0);
  endtask

  // R4, R5, R6: every rank against every request pattern
  task automatic t_matrix;
    int rise;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] below;
        int exp;
        below = 4'h0;
        for (int k = 0; k < 4; k++) if (k > s) below[k] = 1'b1;
        exp = ((4'(p) & below) != 4'h0) ? LONG : SHORT;
        release_and_time(2'(s), 4'(p), -1, 4'h0, rise);
        chk((exp == LONG) ? "R5/R6" : "R4/R6", rise, exp);
      end
    end
  endtask

  // R7: lower request appearing inside and after the short window
  task automatic t_extend;
    int rise;
    release_and_time(2'd0, 4'h0, 5, 4'b0100, rise);
    chk("R7", rise, LONG);
    release_and_time(2'd1, 4'b0001, 8, 4'b1001, rise);
    chk("R7", rise, LONG);
    release_and_time(2'd0, 4'h0, SHORT + 2, 4'b1000, rise);
    chk("R7", rise, SHORT);
  endtask

  initial begin
    t_reset();
    t_want();
    t_dack();
    t_matrix();
    t_extend();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule